// File: doc/BRIEF.md
# Dual-Port Sample Interleaver

This block merges two half-rate sample ports into a single full-rate word stream for a current-steering converter core. Ports A and B each carry one 14-bit unsigned offset-binary code per pair of output cycles. An internal phase bit alternates every cycle. When the phase is 0 the block captures a pair of samples and the mode. The following two output cycles then send that pair in the order the mode selects.

There are four orderings. The normal order alternates A and B. The duplicate order repeats each A sample. The invert order follows each A sample with its mirror about midscale. The zero-stuff order follows each A sample with the midscale code. The mode select is one-hot and is only looked at on a capture cycle, so a mode change never splits a pair. A sleep input parks the stream at midscale and holds the phase at 0. The first pair captured after sleep is the first one sent.

Top module: `dual_port_interleaver`

## Requirements
- R1: After reset and while sleep is low, `phase_o` toggles on every clock. A capture happens on each cycle in which `phase_o` is 0.
- R2: With a valid one-hot mode at capture, the output on the cycle after capture equals the port A code presented at capture.
- R3: Mode bit 0 (normal): on the second cycle of the pair the output equals the port B code captured with it.
- R4: Mode bit 1 (duplicate): on the second cycle the output repeats the captured A code, and port B has no effect on the output.
- R5: Mode bit 2 (invert): on the second cycle the output is the bitwise complement of the captured A code, i.e. 16383 − a.
- R6: Mode bit 3 (zero-stuff): on the second cycle the output is the midscale code 14'h2000.
- R7: If the mode seen at capture has no bit set, or more than one bit set, both words of that pair are 14'h2000. A mode change while `phase_o` is 1 does not alter the pair in progress.
- R8: While `sleep_i` is high, the output is 14'h2000 on the next cycle and `phase_o` is 0. The first cycle with sleep low is a capture cycle.
- R9: A synchronous active-low reset sets the output to 14'h2000 and `phase_o` to 0, and clears the held second word to midscale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate output clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sleep_i | input | 1 | Sleep request, active high |
| mode_i | input | 4 | One-hot ordering select: bit0 normal, bit1 duplicate, bit2 invert, bit3 zero-stuff |
| a_i | input | 14 | Port A sample code |
| b_i | input | 14 | Port B sample code |
| phase_o | output | 1 | Current phase; 0 marks the capture cycle of a pair |
| code_o | output | 14 | Full-rate output code, offset binary |

## Verification
The bench builds the block with its default 14-bit width. That makes the extreme codes 0 and 16383 and the midscale 8192 directly reachable, so the invert mirror can be checked at both ends of the range. The bench changes the mode on every cycle across a stretch of cycles, which puts mode edits on both phases. It enters sleep at both phases, applies a reset in the middle of a stream, and drives empty and multi-bit modes. Together these cover every transition of the phase bit and of the held second word.

// File: rtl/ilv_pkg.sv
// Shared definitions for the dual-port interleaver.
// Assumes the mode select is four bits, one per output ordering.
package ilv_pkg;

    localparam int MODE_N = 4;

    // Bit positions of the one-hot mode select
    localparam int MB_NORMAL = 0;
    localparam int MB_DUP    = 1;
    localparam int MB_INV    = 2;
    localparam int MB_ZERO   = 3;

    typedef enum logic [1:0] {
        SEQ_NORMAL = 2'd0,
        SEQ_DUP    = 2'd1,
        SEQ_INV    = 2'd2,
        SEQ_ZERO   = 2'd3
    } seq_e;

    typedef struct packed {
        logic valid;
        seq_e seq;
    } mode_t;

endpackage

// File: rtl/ilv_phase.sv
// Phase generator: toggles every cycle, held at 0 in sleep and reset.
// Assumes rst_n is synchronous and active low.
module ilv_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    output logic phase
);
    // Toggle the pair phase; park it at capture phase when idle
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) phase <= 1'b0;
        else                 phase <= ~phase;
    end
endmodule

// File: rtl/ilv_mode_dec.sv
// Mode qualifier: turns a one-hot select into an ordering plus a valid flag.
// Assumes nothing about the select; zero or several set bits give valid = 0.
module ilv_mode_dec
    import ilv_pkg::*;
#(
    parameter int MODES = MODE_N
) (
    input  logic [MODES-1:0] sel,
    output mode_t            mode
);
    localparam int CW = $clog2(MODES + 1);

    logic [CW-1:0] ones;
    logic [1:0]    idx;

    // Count set bits and record the index of the set bit
    always_comb begin
        ones = '0;
        idx  = 2'd0;
        for (int i = 0; i < MODES; i++) begin
            if (sel[i]) begin
                ones = ones + CW'(1);
                idx  = 2'(i);
            end
        end
    end

    // Qualify: exactly one bit set means a usable ordering
    always_comb begin
        mode.valid = (ones == CW'(1));
        mode.seq   = seq_e'(idx);
    end
endmodule

// File: rtl/ilv_word_sel.sv
// Word former: builds both words of a pair from live port codes.
// Assumes offset-binary codes; negation is a mirror about midscale.
module ilv_word_sel
    import ilv_pkg::*;
#(
    parameter int W = 14
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  mode_t        mode,
    output logic [W-1:0] w_first,
    output logic [W-1:0] w_second
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] a_mirror;

    // Mirror each bit of A; complement equals full-scale minus code
    for (genvar g = 0; g < W; g++) begin : g_mirror
        assign a_mirror[g] = ~a[g];
    end

    // Pick the two words of the pair from the qualified ordering
    always_comb begin
        w_first  = MID;
        w_second = MID;
        if (mode.valid) begin
            w_first = a;
            unique case (mode.seq)
                SEQ_NORMAL: w_second = b;
                SEQ_DUP:    w_second = a;
                SEQ_INV:    w_second = a_mirror;
                SEQ_ZERO:   w_second = MID;
            endcase
        end
    end
endmodule

// File: rtl/ilv_pair_hold.sv
// Pair sequencer: sends the first word at capture and holds the second word.
// Assumes phase = 0 marks the capture cycle.
module ilv_pair_hold #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sleep,
    input  logic         phase,
    input  logic [W-1:0] w_first,
    input  logic [W-1:0] w_second,
    output logic [W-1:0] code
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] held_q;

    // Latch the second word of the pair on the capture cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                 held_q <= MID;
        else if (!sleep && !phase)  held_q <= w_second;
    end

    // Drive the output: first word at capture, held word after, midscale when idle
    always_ff @(posedge clk) begin
        if (!rst_n || sleep) code <= MID;
        else if (!phase)     code <= w_first;
        else                 code <= held_q;
    end
endmodule

// File: rtl/dual_port_interleaver.sv
// Dual-port sample interleaver top.
// Merges two half-rate ports into one full-rate stream in a selectable order.
// Assumes the source presents a fresh A/B pair while phase_o is 0.
module dual_port_interleaver
    import ilv_pkg::*;
#(
    parameter int W     = 14,
    parameter int MODES = MODE_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic [MODES-1:0] mode_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    output logic             phase_o,
    output logic [W-1:0]     code_o
);
    mode_t        mode;
    logic [W-1:0] w_first;
    logic [W-1:0] w_second;

    ilv_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .sleep (sleep_i),
        .phase (phase_o)
    );

    ilv_mode_dec #(.MODES(MODES)) u_dec (
        .sel  (mode_i),
        .mode (mode)
    );

    ilv_word_sel #(.W(W)) u_sel (
        .a        (a_i),
        .b        (b_i),
        .mode     (mode),
        .w_first  (w_first),
        .w_second (w_second)
    );

    ilv_pair_hold #(.W(W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep_i),
        .phase    (phase_o),
        .w_first  (w_first),
        .w_second (w_second),
        .code     (code_o)
    );
endmodule

// File: rtl/ilv_checker.sv
// Property checker for the interleaver, attached by bind below.
module ilv_checker #(
    parameter int W     = 14,
    parameter int MODES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic [MODES-1:0] mode_i,
    input logic [W-1:0]     a_i,
    input logic [W-1:0]     b_i,
    input logic             phase_o,
    input logic [W-1:0]     code_o
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    a_r1_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> (phase_o != $past(phase_o)));

    a_r2_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && !sleep_i && $countones(mode_i) == 1) |=> (code_o == $past(a_i)));

    a_r3_normal_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && !sleep_i && mode_i == 4'b0001) ##1 !sleep_i |=> (code_o == $past(b_i, 2)));

    a_r4_dup_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && !sleep_i && mode_i == 4'b0010) ##1 !sleep_i |=> (code_o == $past(a_i, 2)));

    a_r5_inv_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && !sleep_i && mode_i == 4'b0100) ##1 !sleep_i |=> (code_o == ~$past(a_i, 2)));

    a_r6_zero_second: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && !sleep_i && mode_i == 4'b1000) ##1 !sleep_i |=> (code_o == MID));

    a_r7_bad_mode_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_o && !sleep_i && $countones(mode_i) != 1) |=> (code_o == MID));

    a_r8_sleep_park: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (code_o == MID && !phase_o));

    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (code_o == MID && !phase_o));
endmodule

bind dual_port_interleaver ilv_checker #(.W(W), .MODES(MODES)) u_ilv_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_i (sleep_i),
    .mode_i  (mode_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .phase_o (phase_o),
    .code_o  (code_o)
);

// File: tb/test_dual_port_interleaver.sv
// Bench: behavioural reference model compared with the ports every cycle.
module test_dual_port_interleaver;
    localparam int W   = 14;
    localparam int MID = 8192;
    localparam int FS  = 16383;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_i = 1'b0;
    logic [3:0]    mode_i = 4'b0001;
    logic [W-1:0]  a_i = '0;
    logic [W-1:0]  b_i = '0;
    logic          phase_o;
    logic [W-1:0]  code_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // Reference model state
    int    m_ph    = 0;
    int    m_held  = MID;
    int    m_exp   = MID;
    string m_tag   = "R9";
    bit    m_valid = 0;

    always #2 clk = ~clk;

    dual_port_interleaver i_dual_port_interleaver (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep_i),
        .mode_i  (mode_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .phase_o (phase_o),
        .code_o  (code_o)
    );

    function automatic int ones(input logic [3:0] m);
        int n = 0;
        for (int i = 0; i < 4; i++) if (m[i]) n++;
        return n;
    endfunction

    // Compare ports with the model, then drive and advance the model
    task automatic step(input bit rn, input bit sl, input logic [3:0] md,
                        input int a, input int b);
        @(negedge clk);
        if (m_valid) begin
            checks++;
            if (int'(code_o) != m_exp) begin
                errors++;
                $display("FAIL %s code actual %0d expected %0d", m_tag, code_o, m_exp);
            end
            checks++;
            if (int'(phase_o) != m_ph) begin
                errors++;
                $display("FAIL R1 phase actual %0d expected %0d", phase_o, m_ph);
            end
        end
        rst_n = rn; sleep_i = sl; mode_i = md;
        a_i = W'(a); b_i = W'(b);
        if (!rn) begin
            m_ph = 0; m_held = MID; m_exp = MID; m_tag = "R9"; m_valid = 1;
        end else if (sl) begin
            m_ph = 0; m_exp = MID; m_tag = "R8";
        end else if (m_ph == 0) begin
            if (ones(md) != 1) begin
                m_exp = MID; m_held = MID; m_tag = "R7";
            end else begin
                m_exp = a; m_tag = "R2";
                if (md[0]) m_held = b;
                else if (md[1]) m_held = a;
                else if (md[2]) m_held = FS - a;
                else m_held = MID;
            end
            m_ph = 1;
        end else begin
            m_exp = m_held;
            m_tag = (m_tag == "R7") ? "R7" :
                    mode_tag(m_held == b_dummy() ? 0 : 0);
            m_ph = 0;
        end
    endtask

    function automatic int b_dummy();
        return -1;
    endfunction

    // Second-word tag from the mode captured last
    logic [3:0] cap_mode = 4'b0001;
    always @(negedge clk) if (rst_n && !sleep_i && phase_o == 1'b0) cap_mode <= mode_i;

    function automatic string mode_tag(input int unused);
        if (cap_mode[0]) return "R3";
        if (cap_mode[1]) return "R4";
        if (cap_mode[2]) return "R5";
        return "R6";
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 4'b0001, 100, 200);
        // R3: normal interleave, varied codes
        for (int i = 0; i < 12; i++) step(1, 0, 4'b0001, (i * 1237 + 5) % 16384, (i * 4099 + 77) % 16384);
        // R4: duplicate, B swings widely and must not matter
        for (int i = 0; i < 10; i++) step(1, 0, 4'b0010, (i * 911) % 16384, (i % 2) ? FS : 0);
        // R5: invert, including both range ends and midscale
        step(1, 0, 4'b0100, 0, 1); step(1, 0, 4'b0100, 5, 5);
        step(1, 0, 4'b0100, FS, 3); step(1, 0, 4'b0100, 9, 9);
        step(1, 0, 4'b0100, MID, 3); step(1, 0, 4'b0100, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 0, 4'b0100, (i * 2777) % 16384, 0);
        // R6: zero-stuff
        for (int i = 0; i < 8; i++) step(1, 0, 4'b1000, (i * 3001 + 1) % 16384, 55);
        // R7: empty and multi-bit modes
        for (int i = 0; i < 4; i++) step(1, 0, 4'b0000, 1234 + i, 4321);
        for (int i = 0; i < 4; i++) step(1, 0, 4'b0110, 777 + i, 888);
        for (int i = 0; i < 4; i++) step(1, 0, 4'b1111, 60 + i, 70);
        // R7: mode edited on every cycle, so edits land on both phases
        for (int i = 0; i < 16; i++) step(1, 0, 4'(1 << (i % 4)), (i * 1500 + 3) % 16384, (i * 700) % 16384);
        // R8: sleep entered at capture phase, then released
        for (int i = 0; i < 4; i++) step(1, 1, 4'b0001, 4000, 5000);
        for (int i = 0; i < 5; i++) step(1, 0, 4'b0001, 300 + i, 600 + i);
        // R8: sleep entered mid-pair
        for (int i = 0; i < 3; i++) step(1, 1, 4'b0100, 1, 2);
        for (int i = 0; i < 6; i++) step(1, 0, 4'b0100, 10 + i, 0);
        // R9: reset in the middle of a stream
        step(1, 0, 4'b0001, 11, 22);
        step(0, 0, 4'b0001, 33, 44);
        for (int i = 0; i < 6; i++) step(1, 0, 4'b0010, 50 + i, 99);
        step(1, 0, 4'b0001, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule